// File: doc/BRIEF.md
# Page Write Buffer with In-Page Wrap

This block sits between a serial-bus protocol controller and a byte-wide nonvolatile array. A write transaction begins when the controller hands over the start address. The data bytes that follow are gathered into a page latch of 2^PAGE_W bytes (32 by default). Each accepted byte goes to the current in-page offset. The offset then advances and wraps inside the same page, so the upper address bits never change during a transaction. A valid mask records which offsets hold new data.

When the controller reports a bus STOP, it also says whether the STOP fell in the slot directly after a data byte's acknowledge. In that case, and only if at least one byte was accepted, the buffer starts a timed write cycle. During that cycle it holds `busy`, issues one array write request per received offset in ascending order, and finally moves the address counter to the location after the last written byte. A STOP in any other slot throws the buffered bytes away. Protection policy is decided outside the block and arrives as a per-byte allow signal.

The write time is a parameter in clock cycles (`WRITE_CYCLES`). The default matches 5 ms at 50 MHz, and it must be at least the page size.

Top module: `page_write_buffer`

## Requirements
- R1: After reset `busy` is 0, `mem_we` is 0 and `cur_addr` is 0.
- R2: `addr_load` sets `cur_addr` to `addr_in`. Each `byte_vld` pulse then increments the low PAGE_W bits of `cur_addr` modulo 2^PAGE_W and leaves the upper bits unchanged.
- R3: When the offset wraps onto a location already filled in the same transaction, the newer byte replaces the older one, and only the newer value reaches the array.
- R4: A `stop_pulse` with `stop_slot_ok`=1, when at least one byte was accepted, raises `busy` on the next clock edge.
- R5: A `stop_pulse` with `stop_slot_ok`=0 starts no write cycle, issues no array writes and empties the latch.
- R6: `busy` stays high for exactly `WRITE_CYCLES` consecutive cycles.
- R7: During a write cycle, each received offset is written exactly once at address {page, offset}, in ascending offset order. No write request appears outside `busy`, and no other array location changes.
- R8: When `busy` falls, `cur_addr` equals {page, (last accepted offset + 1) mod 2^PAGE_W}.
- R9: A byte presented with `byte_allow`=0 is not stored and not written, but the offset still advances past it.
- R10: While `busy` is high, `addr_load`, `byte_vld` and `stop_pulse` have no effect on `cur_addr`, the latch or the array writes.
- R11: A transaction that loads an address and then STOPs with no accepted byte starts no write cycle, even when `stop_slot_ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Pulse: start address of a new write is on `addr_in` |
| addr_in | input | ADDR_W | Start address |
| byte_vld | input | 1 | Pulse: a data byte was received |
| byte_data | input | 8 | Received data byte |
| byte_allow | input | 1 | 1 when the current byte may be stored |
| stop_pulse | input | 1 | Pulse: STOP seen on the bus |
| stop_slot_ok | input | 1 | 1 when the STOP came right after a data byte's acknowledge |
| busy | output | 1 | Write cycle in progress |
| mem_we | output | 1 | Array write request |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| cur_addr | output | ADDR_W | Address counter |

## Verification
Every input pulse is registered once, so its effect on `cur_addr` and on the start of `busy` is sampled at the falling edge right after the edge that took the pulse. The bench drives on falling edges and checks there. Array write requests are collected at rising edges during the first 2^PAGE_W cycles of `busy`. The bench counts the `busy` cycles and expects exactly `WRITE_CYCLES` of them. It checks `cur_addr` at the first falling edge where `busy` is low again, because the final address is loaded on the same edge that drops `busy`. The collected array image is then compared in full against the image the bench expects from the bytes it sent.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pwb_latch.sv
module pwb_latch
  import pwb_pkg::*;
#(
  parameter int PAGE_W = 5,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [PAGE_W-1:0]     wr_off,
  input  byte_t                 wr_data,
  input  logic [PAGE_W-1:0]     rd_off,
  output byte_t                 rd_data,
  output logic [PAGE_BYTES-1:0] mask,
  output logic                  any_vld
);

  byte_t                 data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_d, mask_q;

  // one storage byte per page offset, loaded only when addressed
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_cell
    logic cell_en;
    assign cell_en = wr_en && (wr_off == PAGE_W'(g));
    always_ff @(posedge clk) begin
      if (cell_en) data_q[g] <= wr_data;
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (clr) begin
      mask_d = '0;
    end else if (wr_en) begin
      mask_d[wr_off] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign rd_data = data_q[rd_off];
  assign mask    = mask_q;
  assign any_vld = |mask_q;

endmodule

// File: rtl/pwb_addr_ctr.sv
module pwb_addr_ctr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  localparam int PG_W  = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic              finish,
  input  logic [PAGE_W-1:0] finish_off,
  output logic [PG_W-1:0]   page,
  output logic [PAGE_W-1:0] off
);

  logic [PG_W-1:0]   page_d, page_q;
  logic [PAGE_W-1:0] off_d, off_q;

  always_comb begin
    page_d = page_q;
    off_d  = off_q;
    if (load) begin
      page_d = load_addr[ADDR_W-1:PAGE_W];
      off_d  = load_addr[PAGE_W-1:0];
    end else if (finish) begin
      off_d  = finish_off;
    end else if (step) begin
      // the offset field is exactly PAGE_W bits, so the carry drops off
      off_d  = off_q + PAGE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
    end else begin
      page_q <= page_d;
      off_q  <= off_d;
    end
  end

  assign page = page_q;
  assign off  = off_q;

endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
  parameter int WRITE_CYCLES = 250000,
  parameter int PAGE_W       = 5,
  localparam int CNT_W       = $clog2(WRITE_CYCLES + 1),
  localparam int SCAN_W      = PAGE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              scan_act,
  output logic [PAGE_W-1:0] scan_off
);

  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [SCAN_W-1:0] SCAN_END = SCAN_W'(1 << PAGE_W);

  logic              busy_d, busy_q;
  logic [CNT_W-1:0]  cnt_d, cnt_q;
  logic [SCAN_W-1:0] scan_d, scan_q;

  assign done = busy_q && (cnt_q == CNT_LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    scan_d = scan_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        scan_d = '0;
      end
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      if (scan_q != SCAN_END) scan_d = scan_q + SCAN_W'(1);
      if (done) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      scan_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      scan_q <= scan_d;
    end
  end

  assign busy     = busy_q;
  assign scan_act = busy_q && (scan_q != SCAN_END);
  assign scan_off = scan_q[PAGE_W-1:0];

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              byte_allow,
  input  logic              stop_pulse,
  input  logic              stop_slot_ok,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;

  logic                  idle;
  logic                  acc_load, acc_byte, acc_stop;
  logic                  commit, discard, done;
  logic                  lat_wr, lat_clr, any_vld;
  logic [PAGE_BYTES-1:0] mask;
  logic [PG_W-1:0]       page;
  logic [PAGE_W-1:0]     off;
  logic [PAGE_W-1:0]     last_d, last_q;
  logic                  scan_act;
  logic [PAGE_W-1:0]     scan_off;
  byte_t                 rd_data;

  // inputs count only between write cycles; load wins over byte, byte over stop
  assign idle     = !busy;
  assign acc_load = idle && addr_load;
  assign acc_byte = idle && !addr_load && byte_vld;
  assign acc_stop = idle && !addr_load && !byte_vld && stop_pulse;
  assign commit   = acc_stop && stop_slot_ok && any_vld;
  assign discard  = acc_stop && !commit;
  assign lat_wr   = acc_byte && byte_allow;
  assign lat_clr  = acc_load || discard || done;

  always_comb begin
    last_d = last_q;
    if (lat_wr) last_d = off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end

  pwb_latch #(.PAGE_W(PAGE_W)) i_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (lat_clr),
    .wr_en   (lat_wr),
    .wr_off  (off),
    .wr_data (byte_data),
    .rd_off  (scan_off),
    .rd_data (rd_data),
    .mask    (mask),
    .any_vld (any_vld)
  );

  pwb_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (acc_load),
    .load_addr  (addr_in),
    .step       (acc_byte),
    .finish     (done),
    .finish_off (last_q + PAGE_W'(1)),
    .page       (page),
    .off        (off)
  );

  pwb_cycle_timer #(.WRITE_CYCLES(WRITE_CYCLES), .PAGE_W(PAGE_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (commit),
    .busy     (busy),
    .done     (done),
    .scan_act (scan_act),
    .scan_off (scan_off)
  );

  assign mem_we    = scan_act && mask[scan_off];
  assign mem_addr  = {page, scan_off};
  assign mem_wdata = rd_data;
  assign cur_addr  = {page, off};

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W       = 13,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 250000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_load,
  input logic              byte_vld,
  input logic              stop_pulse,
  input logic              stop_slot_ok,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] cur_addr
);

  logic [31:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (busy) len_q <= len_q + 32'd1;
    else           len_q <= '0;
  end

  // R7
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R7
  we_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |->
      ((mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])) &&
       (mem_addr[PAGE_W-1:0] > $past(mem_addr[PAGE_W-1:0]))));

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_pulse && stop_slot_ok && !addr_load && !byte_vld));

  // R5
  bad_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_pulse && !stop_slot_ok) |=> !busy);

  // R10
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_addr));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_q == 32'(WRITE_CYCLES)));

endmodule

bind page_write_buffer pwb_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
) i_pwb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_load    (addr_load),
  .byte_vld     (byte_vld),
  .stop_pulse   (stop_pulse),
  .stop_slot_ok (stop_slot_ok),
  .busy         (busy),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .cur_addr     (cur_addr)
);

// File: tb/test_page_write_buffer.sv
`timescale 1ns/1ps
module test_page_write_buffer;
  localparam int ADDR_W = 8;
  localparam int PAGE_W = 5;
  localparam int WCYC   = 40;
  localparam int PB     = 1 << PAGE_W;
  localparam int MEMSZ  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load = 1'b0, byte_vld = 1'b0, byte_allow = 1'b0;
  logic stop_pulse = 1'b0, stop_slot_ok = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [7:0] byte_data = '0;
  logic busy, mem_we;
  logic [ADDR_W-1:0] mem_addr, cur_addr;
  logic [7:0] mem_wdata;

  always #10 clk = ~clk;

  page_write_buffer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WCYC))
  i_page_write_buffer (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_allow(byte_allow),
    .stop_pulse(stop_pulse), .stop_slot_ok(stop_slot_ok), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_addr(cur_addr)
  );

  int checks = 0, errors = 0;
  logic [7:0] obs_mem [MEMSZ];
  logic [7:0] exp_mem [MEMSZ];
  int wr_total = 0;
  int stray_we = 0;

  // array model fed by the write requests
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMSZ; i++) obs_mem[i] = 8'h00;
    end else if (mem_we) begin
      obs_mem[mem_addr] = mem_wdata;
      wr_total = wr_total + 1;
      if (!busy) stray_we = stray_we + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int next_off(input int o);
    return (o + 1) % PB;
  endfunction

  task automatic mem_compare(input string req);
    int bad = 0, fa = 0;
    for (int i = 0; i < MEMSZ; i++)
      if (obs_mem[i] !== exp_mem[i]) begin
        if (bad == 0) fa = i;
        bad++;
      end
    chk(bad == 0, req, "array image mismatches", bad, 0);
    if (bad != 0)
      $display("  first at %0d: actual %0d expected %0d", fa, obs_mem[fa], exp_mem[fa]);
  endtask

  // allow_mode: 0 all, 1 alternating, 2 random
  task automatic run_txn(input int start, input int n, input int allow_mode,
                         input bit slot_ok, input bit poke_busy, input string tag);
    logic [7:0] bufd [PB];
    bit bmask [PB];
    int off, page, last, nacc, w0;
    bit commit;
    off = start % PB; page = start / PB; last = -1; nacc = 0;
    for (int i = 0; i < PB; i++) begin bmask[i] = 0; bufd[i] = 8'h00; end
    addr_load = 1'b1; addr_in = ADDR_W'(start);
    @(negedge clk); addr_load = 1'b0;
    chk(cur_addr == ADDR_W'(start), "R2", {tag, " load"}, cur_addr, start);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d; bit al;
      d = 8'($urandom);
      al = (allow_mode == 0) ? 1'b1 : (allow_mode == 1) ? (k % 2 == 0) : ($urandom % 4 != 0);
      byte_vld = 1'b1; byte_data = d; byte_allow = al;
      @(negedge clk); byte_vld = 1'b0; byte_allow = 1'b0;
      if (al) begin bufd[off] = d; bmask[off] = 1; last = off; end
      off = next_off(off);
    end
    for (int i = 0; i < PB; i++) nacc += bmask[i];
    chk(cur_addr == ADDR_W'(page * PB + off), "R2", {tag, " offset after bytes"},
        cur_addr, page * PB + off);
    commit = slot_ok && (nacc > 0);
    w0 = wr_total;
    stop_pulse = 1'b1; stop_slot_ok = slot_ok;
    @(negedge clk); stop_pulse = 1'b0; stop_slot_ok = 1'b0;
    if (!slot_ok)
      chk(busy == 1'b0, "R5", {tag, " busy after misplaced stop"}, busy, 0);
    else if (nacc == 0)
      chk(busy == 1'b0, "R11", {tag, " busy without data"}, busy, 0);
    else
      chk(busy == 1'b1, "R4", {tag, " busy after stop"}, busy, 1);
    if (commit) begin
      int cyc = 0;
      while (busy && cyc < WCYC + 20) begin
        if (poke_busy && cyc == 3) begin addr_load = 1'b1; addr_in = ~ADDR_W'(start); end
        if (poke_busy && cyc == 4) begin addr_load = 1'b0; byte_vld = 1'b1; byte_allow = 1'b1; byte_data = 8'h5a; end
        if (poke_busy && cyc == 5) begin byte_vld = 1'b0; byte_allow = 1'b0; stop_pulse = 1'b1; stop_slot_ok = 1'b1; end
        if (poke_busy && cyc == 6) begin stop_pulse = 1'b0; stop_slot_ok = 1'b0; end
        cyc++;
        @(negedge clk);
      end
      chk(cyc == WCYC, "R6", {tag, " busy length"}, cyc, WCYC);
      for (int i = 0; i < PB; i++) if (bmask[i]) exp_mem[page * PB + i] = bufd[i];
      chk((wr_total - w0) == nacc, "R7", {tag, " write count"}, wr_total - w0, nacc);
      chk(cur_addr == ADDR_W'(page * PB + next_off(last)),
          poke_busy ? "R10" : "R8", {tag, " final address"},
          cur_addr, page * PB + next_off(last));
    end else begin
      repeat (3) @(negedge clk);
      chk(wr_total == w0, slot_ok ? "R11" : "R5", {tag, " writes"}, wr_total - w0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEMSZ; i++) exp_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(mem_we == 1'b0, "R1", "mem_we in reset", mem_we, 0);
    chk(cur_addr == '0, "R1", "cur_addr in reset", cur_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_txn(8'h45, 1, 0, 1'b1, 1'b0, "single byte");
    mem_compare("R7");
    run_txn(8'h3e, PB + 3, 0, 1'b1, 1'b0, "wrap overwrite");
    mem_compare("R3");
    run_txn(8'h80, 10, 1, 1'b1, 1'b0, "alternate allow");
    mem_compare("R9");
    run_txn(8'hc0, 6, 0, 1'b0, 1'b0, "misplaced stop");
    mem_compare("R5");
    run_txn(8'h20, 0, 0, 1'b1, 1'b0, "no data");
    run_txn(8'ha7, 4, 0, 1'b1, 1'b1, "poke during busy");
    mem_compare("R10");
    run_txn(8'h1f, PB, 0, 1'b1, 1'b0, "full page from end");
    mem_compare("R7");
    for (int t = 0; t < 24; t++) begin
      int st, nb, md;
      bit ok;
      st = $urandom % MEMSZ;
      nb = $urandom % (PB + 8);
      md = $urandom % 3;
      ok = ($urandom % 4 != 0);
      run_txn(st, nb, md, ok, 1'b0, "random");
    end
    mem_compare("R7");
    chk(stray_we == 0, "R7", "writes outside busy", stray_we, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule